// File: doc/BRIEF.md
# Indirect Configuration Register Window

This bridge lets a processor reach a bank of 28 byte-wide configuration registers through two 32-bit words. The words are selected by a single address bit. The control word (address 0) holds a register index, a write byte and a write-request flag. When software writes the control word with the request flag set, the bridge starts an internal write. The flag then reads back as 1 until that write has landed, and it clears by itself. When software writes the control word with the flag clear, only the index changes, and this starts a read. The data word (address 1) returns the selected register's contents after a fixed pipeline delay. It also returns an interrupt indication, which is derived from the bank's event-flag register.

One register, index 9, collects hardware event bits. The `hw_event` input ORs bits into it on any cycle, so it can change without a bus write. Index 20, index 21 and every index above 27 hold no storage. Writes to them are discarded and reads of them return zero. The bridge takes no new control-word write while an internal write is still in progress.

Top module: `cfgwin_bridge`

## Requirements
- R1: After reset, both words read as zero, with the request flag clear, the index at 0 and the write byte at 0.
- R2: The control word has this layout: bit 16 is the write-request/busy flag, bits [14:8] are the register index, bits [7:0] are the write byte, and every other bit reads 0. A control write with bit 16 clear changes only the index and the write byte and starts no register write.
- R3: A control write with bit 16 set makes bit 16 read 1 for exactly 4 cycles after the launching edge. On the edge that clears it, the write byte is stored into the indexed register.
- R4: A control-word write that arrives while bit 16 reads 1 is dropped entirely: the index, the write byte and the register bank keep their values.
- R5: Data-word bits [7:0] show the contents of the currently indexed register as they were 6 clock edges earlier. A new index is therefore visible exactly 6 cycles after the edge that captured it, and not before.
- R6: Register reset values, indices 0..27 in hex: 0C AA 78 00 00 FF 03 51 3F 00 00 04 04 04 04 04 04 0A 0A 00 00 00 C0 34 07 44 1F 00.
- R7: Index 20, index 21 and indices above 27 ignore writes and read as 0. An out-of-range index does not alias onto another register.
- R8: Each set bit of `hw_event` sets the matching bit of register 9 at the next edge. If a bus write to register 9 lands on the same edge, the stored value is the write byte ORed with the event bits.
- R9: Data-word bit 8 is 1 exactly when register 9 is nonzero. It follows register 9 with no pipeline delay. Data-word bits [31:9] read 0.
- R10: Bus writes to the data word (address 1) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| bus_valid | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable, qualified by bus_valid |
| bus_addr | input | 1 | Word select: 0 control word, 1 data word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word (combinational) |
| hw_event | input | 8 | Hardware event bits ORed into register 9 |

## Verification
Two activities can meet on the same edge: a pending bus write to register 9 can land on the very cycle that a hardware event sets a bit there. The bench counts cycles from the launching edge and raises `hw_event` only during the fourth busy cycle. It then reads register 9 back and expects the union of the written byte and the event bit; losing either one is a failure. A second collision is a control write issued one cycle after a launch, which must vanish while the first write still completes.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  localparam int NUM_REGS  = 28;
  localparam int IDX_W     = 7;
  localparam int DAT_W     = 8;
  localparam int FLAG_IDX  = 9;
  localparam int RSVD_LO   = 20;
  localparam int RSVD_HI   = 21;
  localparam int REQ_BIT   = 16;
  localparam int IDX_LSB   = 8;
  localparam int WR_CYCLES = 4;
  localparam int RD_LAT    = 6;

  function automatic logic [DAT_W-1:0] reg_default(input int i);
    case (i)
      0:  return 8'h0C;
      1:  return 8'hAA;
      2:  return 8'h78;
      5:  return 8'hFF;
      6:  return 8'h03;
      7:  return 8'h51;
      8:  return 8'h3F;
      11, 12, 13, 14, 15, 16: return 8'h04;
      17, 18: return 8'h0A;
      22: return 8'hC0;
      23: return 8'h34;
      24: return 8'h07;
      25: return 8'h44;
      26: return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic has_storage(input int i);
    return (i >= 0) && (i < NUM_REGS) && (i != RSVD_LO) && (i != RSVD_HI);
  endfunction

endpackage

// File: rtl/cfgwin_ctl.sv
module cfgwin_ctl #(
  parameter int IDX_W     = cfgwin_pkg::IDX_W,
  parameter int DAT_W     = cfgwin_pkg::DAT_W,
  parameter int REQ_BIT   = cfgwin_pkg::REQ_BIT,
  parameter int IDX_LSB   = cfgwin_pkg::IDX_LSB,
  parameter int WR_CYCLES = cfgwin_pkg::WR_CYCLES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_word,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic [DAT_W-1:0] wdat,
  output logic             commit
);

  localparam int CNT_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [DAT_W-1:0] wdat_q, wdat_d;
  logic             accept;
  logic             upd_en;

  assign accept = wr_en && !busy_q;
  assign commit = busy_q && (cnt_q == LAST);
  assign upd_en = accept || busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    wdat_d = wdat_q;
    if (accept) begin
      idx_d  = wr_word[IDX_LSB +: IDX_W];
      wdat_d = wr_word[DAT_W-1:0];
      busy_d = wr_word[REQ_BIT];
      cnt_d  = '0;
    end else if (busy_q) begin
      if (commit) busy_d = 1'b0;
      else        cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      wdat_q <= '0;
    end else if (upd_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      wdat_q <= wdat_d;
    end
  end

  assign busy = busy_q;
  assign idx  = idx_q;
  assign wdat = wdat_q;

  // R4: control writes during busy leave index and byte untouched
  assert_busy_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_en) |=> ($stable(idx_q) && $stable(wdat_q)));

  // R3: busy only falls after the full write window
  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/cfgwin_bank.sv
module cfgwin_bank #(
  parameter int NUM_REGS = cfgwin_pkg::NUM_REGS,
  parameter int IDX_W    = cfgwin_pkg::IDX_W,
  parameter int DAT_W    = cfgwin_pkg::DAT_W,
  parameter int FLAG_IDX = cfgwin_pkg::FLAG_IDX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DAT_W-1:0] wr_dat,
  input  logic [DAT_W-1:0] evt,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DAT_W-1:0] rd_val,
  output logic [DAT_W-1:0] flag_val
);

  logic [NUM_REGS-1:0][DAT_W-1:0] regq;
  logic                           wr_ok;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (cfgwin_pkg::has_storage(i)) begin : g_store
      logic [DAT_W-1:0] q, d;
      logic             hit, en;
      assign hit = commit && (wr_idx == IDX_W'(i));
      if (i == FLAG_IDX) begin : g_flag
        assign en = hit || (|evt);
        assign d  = (hit ? wr_dat : q) | evt;
      end else begin : g_plain
        assign en = hit;
        assign d  = wr_dat;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= cfgwin_pkg::reg_default(i);
        else if (en) q <= d;
      end
      assign regq[i] = q;
    end else begin : g_none
      assign regq[i] = '0;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == IDX_W'(i)) rd_val = regq[i];
  end

  always_comb begin
    wr_ok = 1'b0;
    for (int i = 0; i < NUM_REGS; i++)
      if ((wr_idx == IDX_W'(i)) && cfgwin_pkg::has_storage(i)) wr_ok = 1'b1;
  end

  assign flag_val = regq[FLAG_IDX];

  // R8: every event bit is present in the flag register one edge later
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((regq[FLAG_IDX] & $past(evt)) == $past(evt)));

  // R7: a landing write to a storage-less index changes nothing
  assert_rsvd_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr_ok && !(|evt)) |=> $stable(regq));

endmodule

// File: rtl/cfgwin_rdpipe.sv
module cfgwin_rdpipe #(
  parameter int DEPTH = cfgwin_pkg::RD_LAT,
  parameter int W     = cfgwin_pkg::DAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [DEPTH-1:0][W-1:0] stg_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stg
    logic [W-1:0] d;
    if (k == 0) begin : g_head
      assign d = din;
    end else begin : g_body
      assign d = stg_q[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[k] <= '0;
      else        stg_q[k] <= d;
    end
  end

  assign dout = stg_q[DEPTH-1];

endmodule

// File: rtl/cfgwin_bridge.sv
module cfgwin_bridge #(
  parameter int NUM_REGS  = cfgwin_pkg::NUM_REGS,
  parameter int WR_CYCLES = cfgwin_pkg::WR_CYCLES,
  parameter int RD_LAT    = cfgwin_pkg::RD_LAT
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_we,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [7:0]  hw_event
);

  localparam int IDX_W = cfgwin_pkg::IDX_W;
  localparam int DAT_W = cfgwin_pkg::DAT_W;

  logic             ctl_wr;
  logic             busy, commit;
  logic [IDX_W-1:0] idx;
  logic [DAT_W-1:0] wdat, look_val, flag_val, pipe_val;
  logic [31:0]      ctl_word, dat_word;

  assign ctl_wr = bus_valid && bus_we && (bus_addr == 1'b0);

  cfgwin_ctl #(.WR_CYCLES(WR_CYCLES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wr_word(bus_wdata),
    .busy(busy), .idx(idx), .wdat(wdat), .commit(commit)
  );

  cfgwin_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .commit(commit), .wr_idx(idx), .wr_dat(wdat),
    .evt(hw_event), .rd_idx(idx), .rd_val(look_val), .flag_val(flag_val)
  );

  cfgwin_rdpipe #(.DEPTH(RD_LAT), .W(DAT_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .din(look_val), .dout(pipe_val)
  );

  always_comb begin
    ctl_word = '0;
    ctl_word[cfgwin_pkg::REQ_BIT] = busy;
    ctl_word[cfgwin_pkg::IDX_LSB +: IDX_W] = idx;
    ctl_word[DAT_W-1:0] = wdat;
    dat_word = '0;
    dat_word[DAT_W] = |flag_val;
    dat_word[DAT_W-1:0] = pipe_val;
  end

  assign bus_rdata = bus_addr ? dat_word : ctl_word;

endmodule

// File: tb/cfgwin_bridge_tb.sv
module cfgwin_bridge_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_we, bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  hw_event;

  always #5 clk = ~clk;

  cfgwin_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_event(hw_event)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit chk_en = 0;

  // behavioural reference
  logic [7:0] m_bank [28];
  logic       m_busy;
  int         m_cnt;
  logic [6:0] m_idx;
  logic [7:0] m_wdat;
  logic [7:0] m_q [$];

  function automatic logic [7:0] dflt(input int i);
    logic [7:0] t [28] = '{8'h0C, 8'hAA, 8'h78, 8'h00, 8'h00, 8'hFF, 8'h03, 8'h51,
                           8'h3F, 8'h00, 8'h00, 8'h04, 8'h04, 8'h04, 8'h04, 8'h04,
                           8'h04, 8'h0A, 8'h0A, 8'h00, 8'h00, 8'h00, 8'hC0, 8'h34,
                           8'h07, 8'h44, 8'h1F, 8'h00};
    return t[i];
  endfunction

  function automatic logic [7:0] m_look(input logic [6:0] ix);
    if (ix < 7'd28) return m_bank[ix];
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 28; i++) m_bank[i] = dflt(i);
    m_busy = 0; m_cnt = 0; m_idx = '0; m_wdat = '0;
    m_q.delete();
    for (int i = 0; i < 6; i++) m_q.push_back(8'h00);
  endtask

  task automatic model_step();
    logic [7:0] lk;
    bit launch;
    lk = m_look(m_idx);
    launch = bus_valid && bus_we && !bus_addr && !m_busy;
    if (m_busy) begin
      if (m_cnt == 3) begin
        if (m_idx < 7'd28 && m_idx != 7'd20 && m_idx != 7'd21) m_bank[m_idx] = m_wdat;
        m_busy = 0;
      end else m_cnt++;
    end
    m_bank[9] = m_bank[9] | hw_event;
    if (launch) begin
      m_idx = bus_wdata[14:8]; m_wdat = bus_wdata[7:0];
      m_busy = bus_wdata[16]; m_cnt = 0;
    end
    m_q.push_back(lk);
    void'(m_q.pop_front());
  endtask

  initial model_reset();
  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      if (bus_addr) chk("R5 data word", bus_rdata, {23'b0, |m_bank[9], m_q[0]});
      else          chk("R3 control word", bus_rdata, {15'b0, m_busy, 1'b0, m_idx, m_wdat});
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic ctl_wr(input logic [31:0] w);
    bus_valid = 1; bus_we = 1; bus_addr = 0; bus_wdata = w;
    tick();
    bus_valid = 0; bus_we = 0;
  endtask

  task automatic samp(input string tag, input logic [31:0] exp);
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic rd_idx(input int ix);
    ctl_wr(32'(ix) << 8);
    bus_addr = 1;
    repeat (6) tick();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) act=running exp=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; bus_valid = 0; bus_we = 0; bus_addr = 0; bus_wdata = '0; hw_event = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk_en = 1;
    samp("R1 control after reset", 32'h0);
    bus_addr = 1;
    samp("R1 data after reset", 32'h0);
    tick();

    for (int i = 0; i < 28; i++) begin
      rd_idx(i);
      samp((i == 20 || i == 21) ? "R7 reserved read" : "R6 default", {24'b0, dflt(i)});
      tick();
    end

    // R3 write timing
    ctl_wr(32'h0001_035A);
    bus_addr = 0;
    samp("R3 busy after launch", 32'h0001_035A);
    repeat (3) tick();
    samp("R3 busy in last cycle", 32'h0001_035A);
    tick();
    samp("R3 busy cleared", 32'h0000_035A);
    bus_addr = 1;
    repeat (6) tick();
    samp("R3 written value", 32'h0000_005A);
    tick();

    // R4 drop while busy
    ctl_wr(32'h0001_0511);
    ctl_wr(32'h0001_0622);
    samp("R4 dropped write", 32'h0001_0511);
    repeat (4) tick();
    rd_idx(6); samp("R4 bank untouched", {24'b0, dflt(6)}); tick();
    rd_idx(5); samp("R4 first write kept", 32'h0000_0011); tick();

    // R7 storage-less indices
    ctl_wr(32'h0001_14FF); repeat (4) tick();
    rd_idx(20); samp("R7 write to 20 ignored", 32'h0); tick();
    ctl_wr(32'h0001_2877); repeat (4) tick();
    rd_idx(40); samp("R7 index 40 reads 0", 32'h0); tick();
    rd_idx(8); samp("R7 no alias onto 8", {24'b0, dflt(8)}); tick();

    // R9 / R8 event flags
    bus_addr = 1;
    hw_event = 8'h04; tick(); hw_event = 8'h00;
    samp("R9 irq bit set", 32'h0000_013F); tick();
    rd_idx(9); samp("R8 event captured", 32'h0000_0104); tick();

    // R8 collision: write landing together with an event
    ctl_wr(32'h0001_0910);
    repeat (3) tick();
    hw_event = 8'h01; tick(); hw_event = 8'h00;
    rd_idx(9); samp("R8 write+event union", 32'h0000_0111); tick();

    ctl_wr(32'h0001_0900); repeat (4) tick();
    bus_addr = 1;
    @(negedge clk); chk("R9 irq cleared", {31'b0, bus_rdata[8]}, 32'h0);
    tick();

    // R10 data-word writes ignored
    bus_addr = 1; bus_valid = 1; bus_we = 1; bus_wdata = 32'h0001_1234;
    tick();
    bus_valid = 0; bus_we = 0; bus_addr = 0;
    samp("R10 data write ignored", 32'h0000_0900);
    tick();

    // R2 layout: only documented fields captured, bit 16 clear starts no write
    ctl_wr(32'hFFFE_7FAB);
    samp("R2 field layout", 32'h0000_7FAB);
    tick();

    // R5 exact latency: old index visible at 5, new at 6
    ctl_wr(32'h0000_0100);
    bus_addr = 1;
    repeat (5) tick();
    samp("R5 not before 6 cycles", 32'h0);
    tick();
    samp("R5 at 6 cycles", 32'h0000_00AA);
    tick();

    chk_en = 0;
    finish_run();
  end

endmodule